// File: doc/BRIEF.md
# IDE Channel Port Decoder

This block sits between a host I/O bus and one IDE channel. Each cycle it looks at a host I/O access and decides whether the access belongs to the channel's command block, to its control block, or to neither. When the access is claimed, it asserts the matching active-low drive chip select, produces the 3-bit device address, and reports which drive register the access reaches. The register code depends on the access direction, because several offsets hold one register for reads and a different one for writes.

Two decode modes are available. In legacy mode the channel answers at fixed addresses. A parameter chooses the primary or the secondary channel's pair of bases. In native mode the fixed addresses are ignored, and the two base addresses come from base registers that are loaded through a small write port.

Control-block offset 3 is never claimed. An access there raises a forward request so that the access can be passed to a downstream bus. Accesses to control-block offset 2 always drive device address bit 2 high, whatever bit 2 of the host address was. This matters in native mode, where the control base only needs 4-byte alignment.

Top module: `ide_port_decoder`

## Requirements
- R1: After reset, cs1N and cs3N are 1, devAddr is 0, fwdReq is 0, and regCode is 0. Both base registers reset to 0.
- R2: An access whose address falls in the 8-byte command window drives cs1N low in the cycle after the access, with devAddr equal to address bits [2:0]. cs3N stays high and fwdReq stays low.
- R3: Command-block register codes are as follows. Offset 0 is 1 (data). Offset 1 is 2 (error) on a read and 3 (features) on a write. Offsets 2, 3, 4 and 5 are 4, 5, 6 and 7. Offset 6 is 8 (drive) on a read and 9 (head) on a write. Offset 7 is 10 (status) on a read and 11 (command) on a write.
- R4: At control-block offset 2, cs3N goes low and devAddr is 3'b110 regardless of address bit 2. The code is 12 (alternate status) on a read and 13 (device control) on a write. Control offsets 0 and 1 drive cs3N low with devAddr equal to address bits [2:0] and code 14 (reserved).
- R5: An access at control-block offset 3 leaves both chip selects high, devAddr 0 and code 0, and sets fwdReq to 1 for one cycle.
- R6: An access that matches neither window, or a cycle with accValid low, gives idle outputs in the next cycle: both chip selects 1, devAddr 0, fwdReq 0, code 0.
- R7: With nativeMode at 0, the command window is 1F0h–1F7h and the control window is 3F4h–3F7h. With SECONDARY set, these become 170h–177h and 374h–377h. With nativeMode at 1, these fixed windows are not decoded.
- R8: With nativeMode at 1, the windows start at the base registers. A write with barSel=0 loads the command base with its low 3 bits forced to 0. A write with barSel=1 loads the control base with its low 2 bits forced to 0.
- R9: When an address falls in both windows, the command block claims it.
- R10: An access in the same cycle as a base-register write is decoded with the old base. The new base applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nativeMode | input | 1 | 1 selects base-register decode, 0 selects fixed addresses |
| accValid | input | 1 | Host I/O access present this cycle |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| accAddr | input | ADDR_W | Host I/O address |
| barWrEn | input | 1 | Base register write strobe |
| barSel | input | 1 | 0 selects the command base, 1 selects the control base |
| barWrData | input | ADDR_W | Base register write value |
| cs1N | output | 1 | Command-block chip select, active low |
| cs3N | output | 1 | Control-block chip select, active low |
| devAddr | output | 3 | Drive register address |
| fwdReq | output | 1 | Access is to be forwarded downstream |
| regCode | output | 4 | Drive register reached, coded as in R3/R4 |

## Verification
A base-register write and an access can arrive in the same cycle. The bench provokes this by asserting barWrEn and accValid together while moving the command base away from the accessed address. It then judges the result in two steps: that access must still hit the old window, and follow-up accesses must hit the new base and miss the old one. The command and control windows can also claim the same address. The bench places both bases on one 8-byte region and checks that the command block wins, while the remaining decode is swept over every offset, in both directions and both modes, against an arithmetic model.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  typedef enum logic [3:0] {
    REG_NONE     = 4'd0,
    REG_DATA     = 4'd1,
    REG_ERROR    = 4'd2,
    REG_FEATURES = 4'd3,
    REG_SECCNT   = 4'd4,
    REG_SECNUM   = 4'd5,
    REG_CYLLO    = 4'd6,
    REG_CYLHI    = 4'd7,
    REG_DRIVE    = 4'd8,
    REG_HEAD     = 4'd9,
    REG_STATUS   = 4'd10,
    REG_COMMAND  = 4'd11,
    REG_ALTSTAT  = 4'd12,
    REG_DEVCTL   = 4'd13,
    REG_RSVD     = 4'd14
  } regCode_e;

  typedef struct packed {
    logic     hitCmd;
    logic     hitCtl;
    logic     hitFwd;
    logic [2:0] devAddr;
    regCode_e code;
  } decStrobe_t;

endpackage

// File: rtl/ide_dec_ctrl.sv
module ide_dec_ctrl
  import ide_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       cmdMatch,
  input  logic       ctlMatch,
  input  logic [2:0] addrLow,
  output decStrobe_t strobes
);

  localparam logic [1:0] CTL_ALT_OFS = 2'd2;
  localparam logic [1:0] CTL_FWD_OFS = 2'd3;

  regCode_e cmdCode;

  always_comb begin
    unique case (addrLow)
      3'd0: cmdCode = REG_DATA;
      3'd1: cmdCode = accWrite ? REG_FEATURES : REG_ERROR;
      3'd2: cmdCode = REG_SECCNT;
      3'd3: cmdCode = REG_SECNUM;
      3'd4: cmdCode = REG_CYLLO;
      3'd5: cmdCode = REG_CYLHI;
      3'd6: cmdCode = accWrite ? REG_HEAD : REG_DRIVE;
      default: cmdCode = accWrite ? REG_COMMAND : REG_STATUS;
    endcase
  end

  always_comb begin
    strobes = '{hitCmd: 1'b0, hitCtl: 1'b0, hitFwd: 1'b0,
                devAddr: 3'd0, code: REG_NONE};
    if (accValid) begin
      if (cmdMatch) begin
        strobes.hitCmd  = 1'b1;
        strobes.devAddr = addrLow;
        strobes.code    = cmdCode;
      end else if (ctlMatch) begin
        if (addrLow[1:0] == CTL_FWD_OFS) begin
          strobes.hitFwd = 1'b1;
        end else if (addrLow[1:0] == CTL_ALT_OFS) begin
          strobes.hitCtl  = 1'b1;
          strobes.devAddr = {1'b1, addrLow[1:0]};
          strobes.code    = accWrite ? REG_DEVCTL : REG_ALTSTAT;
        end else begin
          strobes.hitCtl  = 1'b1;
          strobes.devAddr = addrLow;
          strobes.code    = REG_RSVD;
        end
      end
    end
  end

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.hitCmd, strobes.hitCtl, strobes.hitFwd}));

  // R9
  cmd_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && cmdMatch) |-> (strobes.hitCmd && !strobes.hitCtl && !strobes.hitFwd));

endmodule

// File: rtl/ide_dec_path.sv
module ide_dec_path
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nativeMode,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              barWrEn,
  input  logic              barSel,
  input  logic [ADDR_W-1:0] barWrData,
  input  decStrobe_t        strobes,
  output logic              cmdMatch,
  output logic              ctlMatch,
  output logic [2:0]        addrLow,
  output logic              cs1N,
  output logic              cs3N,
  output logic [2:0]        devAddr,
  output logic              fwdReq,
  output logic [3:0]        regCode
);

  localparam int NUM_BLK = 2;
  localparam int CMD_LOWB = 3;
  localparam int CTL_LOWB = 2;
  localparam logic [ADDR_W-1:0] CMD_FIXED = SECONDARY ? ADDR_W'('h170) : ADDR_W'('h1F0);
  localparam logic [ADDR_W-1:0] CTL_FIXED = SECONDARY ? ADDR_W'('h374) : ADDR_W'('h3F4);

  logic [ADDR_W-1:0] baseQ [NUM_BLK];

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : gBar
    localparam int LOWB = (gi == 0) ? CMD_LOWB : CTL_LOWB;
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (barWrEn && (barSel == gi[0])) begin
        q <= {barWrData[ADDR_W-1:LOWB], {LOWB{1'b0}}};
      end
    end
    assign baseQ[gi] = q;
  end

  logic [ADDR_W-1:0] cmdBase;
  logic [ADDR_W-1:0] ctlBase;

  assign cmdBase  = nativeMode ? baseQ[0] : CMD_FIXED;
  assign ctlBase  = nativeMode ? baseQ[1] : CTL_FIXED;
  assign cmdMatch = (accAddr[ADDR_W-1:CMD_LOWB] == cmdBase[ADDR_W-1:CMD_LOWB]);
  assign ctlMatch = (accAddr[ADDR_W-1:CTL_LOWB] == ctlBase[ADDR_W-1:CTL_LOWB]);
  assign addrLow  = accAddr[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cs1N    <= 1'b1;
      cs3N    <= 1'b1;
      devAddr <= 3'd0;
      fwdReq  <= 1'b0;
      regCode <= REG_NONE;
    end else begin
      cs1N    <= ~strobes.hitCmd;
      cs3N    <= ~strobes.hitCtl;
      devAddr <= strobes.devAddr;
      fwdReq  <= strobes.hitFwd;
      regCode <= strobes.code;
    end
  end

  // R2
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!cs1N && !cs3N));

  // R5
  fwd_unclaimed_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdReq |-> (cs1N && cs3N && devAddr == 3'd0 && regCode == REG_NONE));

  // R4
  alt_bit2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regCode == REG_ALTSTAT || regCode == REG_DEVCTL) |-> (devAddr[2] && !cs3N));

  // R8
  bar_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baseQ[0][CMD_LOWB-1:0] == '0) && (baseQ[1][CTL_LOWB-1:0] == '0));

endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nativeMode,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              barWrEn,
  input  logic              barSel,
  input  logic [ADDR_W-1:0] barWrData,
  output logic              cs1N,
  output logic              cs3N,
  output logic [2:0]        devAddr,
  output logic              fwdReq,
  output logic [3:0]        regCode
);

  decStrobe_t strobes;
  logic       cmdMatch;
  logic       ctlMatch;
  logic [2:0] addrLow;

  ide_dec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .cmdMatch (cmdMatch),
    .ctlMatch (ctlMatch),
    .addrLow  (addrLow),
    .strobes  (strobes)
  );

  ide_dec_path #(.ADDR_W(ADDR_W), .SECONDARY(SECONDARY)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .nativeMode (nativeMode),
    .accAddr    (accAddr),
    .barWrEn    (barWrEn),
    .barSel     (barSel),
    .barWrData  (barWrData),
    .strobes    (strobes),
    .cmdMatch   (cmdMatch),
    .ctlMatch   (ctlMatch),
    .addrLow    (addrLow),
    .cs1N       (cs1N),
    .cs3N       (cs3N),
    .devAddr    (devAddr),
    .fwdReq     (fwdReq),
    .regCode    (regCode)
  );

  // R6
  idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (cs1N && cs3N && !fwdReq && devAddr == 3'd0 && regCode == 4'd0));

endmodule

// File: tb/ide_port_decoder_bench.sv
`timescale 1ns/1ps
module ide_port_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nativeMode = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [15:0] accAddr = '0;
  logic        barWrEn = 1'b0;
  logic        barSel = 1'b0;
  logic [15:0] barWrData = '0;
  logic        cs1N, cs3N, fwdReq;
  logic [2:0]  devAddr;
  logic [3:0]  regCode;

  int total = 0;
  int bad = 0;
  logic [15:0] cmdB = 16'h0;
  logic [15:0] ctlB = 16'h0;

  always #2 clk = ~clk;

  ide_port_decoder u_ide_port_decoder (
    .clk(clk), .rstN(rstN), .nativeMode(nativeMode), .accValid(accValid),
    .accWrite(accWrite), .accAddr(accAddr), .barWrEn(barWrEn), .barSel(barSel),
    .barWrData(barWrData), .cs1N(cs1N), .cs3N(cs3N), .devAddr(devAddr),
    .fwdReq(fwdReq), .regCode(regCode)
  );

  function automatic logic [9:0] model(input logic [15:0] a, input logic wr,
                                       input logic nat, output string tag);
    logic [15:0] cb, kb;
    logic [3:0]  code;
    cb = nat ? cmdB : 16'h01F0;
    kb = nat ? ctlB : 16'h03F4;
    if (a[15:3] == cb[15:3]) begin
      tag = nat ? "R8/R3" : "R2/R3/R7";
      case (a[2:0])
        3'd0: code = 4'd1;
        3'd1: code = wr ? 4'd3 : 4'd2;
        3'd6: code = wr ? 4'd9 : 4'd8;
        3'd7: code = wr ? 4'd11 : 4'd10;
        default: code = 4'(a[2:0]) + 4'd2;
      endcase
      return {1'b0, 1'b1, a[2:0], 1'b0, code};
    end else if (a[15:2] == kb[15:2]) begin
      if (a[1:0] == 2'd3) begin
        tag = "R5";
        return {1'b1, 1'b1, 3'd0, 1'b1, 4'd0};
      end
      tag = "R4";
      if (a[1:0] == 2'd2) return {1'b1, 1'b0, 3'b110, 1'b0, wr ? 4'd13 : 4'd12};
      return {1'b1, 1'b0, a[2:0], 1'b0, 4'd14};
    end
    tag = nat ? "R7/R6" : "R6";
    return {1'b1, 1'b1, 3'd0, 1'b0, 4'd0};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    logic [9:0] act;
    act = {cs1N, cs3N, devAddr, fwdReq, regCode};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, accAddr, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic wr);
    string tag;
    logic [9:0] exp;
    exp = model(a, wr, nativeMode, tag);
    accValid = 1'b1; accWrite = wr; accAddr = a;
    @(negedge clk);
    check(tag, exp);
    accValid = 1'b0;
    @(negedge clk);
    check("R6 idle", {1'b1, 1'b1, 3'd0, 1'b0, 4'd0});
  endtask

  task automatic barWrite(input logic sel, input logic [15:0] d);
    barWrEn = 1'b1; barSel = sel; barWrData = d;
    @(negedge clk);
    barWrEn = 1'b0;
    if (sel) ctlB = {d[15:2], 2'b00};
    else     cmdB = {d[15:3], 3'b000};
  endtask

  task automatic sweep;
    logic [15:0] bases [5];
    bases = '{16'h0160, 16'h01E0, 16'h0360, 16'h03E0, 16'h0200};
    foreach (bases[i])
      for (int k = 0; k < 64; k++) begin
        access(bases[i] + 16'(k), 1'b0);
        access(bases[i] + 16'(k), 1'b1);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {1'b1, 1'b1, 3'd0, 1'b0, 4'd0});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {1'b1, 1'b1, 3'd0, 1'b0, 4'd0});
    // R1: base registers cleared, native window at address 0
    nativeMode = 1'b1;
    access(16'h0000, 1'b0);
    access(16'h0006, 1'b1);
    // R8: unaligned writes are aligned
    barWrite(1'b0, 16'h020B);
    barWrite(1'b1, 16'h0232);
    nativeMode = 1'b0;
    sweep();
    nativeMode = 1'b1;
    sweep();
    // R9: overlapping windows, command block wins
    barWrite(1'b1, 16'h0209);
    for (int k = 0; k < 16; k++) access(16'h0200 + 16'(k), k[0]);
    // R10: base write in the same cycle as an access
    begin
      string tag;
      logic [9:0] exp;
      exp = model(16'h0209, 1'b1, 1'b1, tag);
      accValid = 1'b1; accWrite = 1'b1; accAddr = 16'h0209;
      barWrEn = 1'b1; barSel = 1'b0; barWrData = 16'h0300;
      @(negedge clk);
      check("R10 old base", exp);
      accValid = 1'b0; barWrEn = 1'b0;
      cmdB = 16'h0300;
      @(negedge clk);
    end
    access(16'h0301, 1'b0);
    access(16'h020F, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule